// File: doc/BRIEF.md
# Processor Status Flag Register

This block keeps the condition flags that software on a 16-bit minicomputer can see and change, and shows them as a single 16-bit status word. The arithmetic unit updates the carry and overflow flags each time it finishes an operation. The floating-point path reports overflow on its own strobe. The shifter supplies a multi-shift link bit. A one-bit accumulator can be written directly. The interrupt arbitration logic loads a 4-bit field that holds the level now running. Two mode bits, paging-on and reject-interrupt, are changed only by software.

Software has two ways in. A whole-word write moves the accumulator into every used flag in one cycle. A bit-operation port clears, sets or loads one chosen bit position. Overflow comes in two kinds. The dynamic overflow flag follows each arithmetic result. The static overflow flag and the floating-point overflow flag latch on any overflow and stay set until software clears them.

A software write always wins over a hardware result in the same cycle. A synchronous master clear wins over everything. Every update shows on `word_o` one clock edge after it is presented.

Top module: `status_flag_reg`

## Requirements
- R1: The status word layout is: one-bit accumulator at bit 2, floating overflow at bit 3, dynamic overflow at bit 4, static overflow at bit 5, carry at bit 6, shift link at bit 7, interrupt level at bits 11:8, paging-on at bit 13, reject-interrupt at bit 14.
- R2: Bits 0, 1, 12 and 15 always read as zero. A word write or a bit operation aimed at one of these positions leaves it at zero and changes no other bit.
- R3: On `alu_done_i`, the carry flag takes `alu_carry_i` and the dynamic overflow flag takes `alu_ovf_i`. An operation with no overflow therefore clears the dynamic overflow flag.
- R4: The static overflow flag is set by `alu_done_i` together with `alu_ovf_i`. It then stays set until software clears it.
- R5: The floating overflow flag is set by `fp_done_i` together with `fp_ovf_i`. A floating operation without overflow leaves it unchanged, and only software clears it.
- R6: `kbit_we_i` loads the accumulator bit from `kbit_i`. `shift_done_i` loads the link bit from `shift_link_i`. `lvl_we_i` loads the level field from `lvl_i`.
- R7: `word_we_i` loads every used bit from `word_i` in one cycle.
- R8: When `bop_en_i` is high, `bop_sel_i` picks the bit position and `bop_op_i` picks the action: 0 clears the bit, 1 sets it, 2 loads `bop_val_i` into it, and 3 has no effect.
- R9: A software write takes priority over any hardware update of the same bit in the same cycle. A bit operation takes priority over a word write for its one bit.
- R10: Reset (`rst_n` low) and a synchronous `mclr_i` each clear the whole word to zero. `mclr_i` takes priority over every other input.
- R11: With no strobe, no write and no clear, the word holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| mclr_i | input | 1 | Synchronous master clear |
| alu_done_i | input | 1 | Arithmetic operation finished |
| alu_carry_i | input | 1 | Carry result |
| alu_ovf_i | input | 1 | Overflow result |
| fp_done_i | input | 1 | Floating operation finished |
| fp_ovf_i | input | 1 | Floating overflow result |
| kbit_we_i | input | 1 | Accumulator bit write strobe |
| kbit_i | input | 1 | Accumulator bit value |
| shift_done_i | input | 1 | Shift finished |
| shift_link_i | input | 1 | Link bit from the shifter |
| lvl_we_i | input | 1 | Level field write strobe |
| lvl_i | input | 4 | Current interrupt level |
| word_we_i | input | 1 | Whole-word write from the accumulator |
| word_i | input | 16 | Word to write |
| bop_en_i | input | 1 | Bit-operation enable |
| bop_sel_i | input | 4 | Target bit position |
| bop_op_i | input | 2 | Bit action (clear, set, load, none) |
| bop_val_i | input | 1 | Value for the load action |
| word_o | output | 16 | Status word |

## Verification
The assertions check the following on every cycle:
- the unused bits stay at zero;
- the master clear empties the word;
- the static and floating overflow flags stay set unless software or a clear touches them;
- the dynamic overflow flag follows each arithmetic result;
- an unopposed word write lands exactly;
- an idle cycle changes nothing.

The bench scenarios are needed for what the assertions do not cover:
- the priority between a software write and a same-cycle hardware strobe;
- a bit operation overriding a word write;
- the no-effect action code;
- bit operations aimed at unused positions;
- the placement of each field in the word.

// File: rtl/status_flag_pkg.sv
package status_flag_pkg;
    localparam int STAT_W = 16;
    localparam int LVL_W  = 4;
    localparam int SEL_W  = $clog2(STAT_W);

    localparam int POS_K    = 2;
    localparam int POS_Z    = 3;
    localparam int POS_Q    = 4;
    localparam int POS_O    = 5;
    localparam int POS_C    = 6;
    localparam int POS_M    = 7;
    localparam int POS_LVL  = 8;
    localparam int POS_PAGE = 13;
    localparam int POS_REJ  = 14;

    localparam logic [STAT_W-1:0] USED_MASK = 16'h6FFC;

    typedef enum logic [1:0] {
        BOP_CLR  = 2'd0,
        BOP_SET  = 2'd1,
        BOP_LOAD = 2'd2,
        BOP_NOP  = 2'd3
    } bop_e;

    typedef struct packed {
        logic             rsv15;
        logic             reject;
        logic             paging;
        logic             rsv12;
        logic [LVL_W-1:0] level;
        logic             m;
        logic             c;
        logic             o;
        logic             q;
        logic             z;
        logic             k;
        logic [1:0]       rsv_lo;
    } stat_word_t;
endpackage

// File: rtl/flag_sw_decode.sv
module flag_sw_decode
    import status_flag_pkg::*;
#(
    parameter int                W    = STAT_W,
    parameter int                SW   = SEL_W,
    parameter logic [W-1:0]      USED = USED_MASK
) (
    input  logic          word_we,
    input  logic [W-1:0]  word_in,
    input  logic          bop_en,
    input  logic [SW-1:0] bop_sel,
    input  logic [1:0]    bop_op,
    input  logic          bop_val,
    output logic [W-1:0]  sw_mask,
    output logic [W-1:0]  sw_val
);
    bop_e op;
    assign op = bop_e'(bop_op);

    for (genvar i = 0; i < W; i++) begin : g_bit
        logic hit;
        logic bop_bit;
        assign hit     = bop_en && (bop_sel == SW'(i)) && (op != BOP_NOP);
        assign bop_bit = (op == BOP_SET) || ((op == BOP_LOAD) && bop_val);
        assign sw_mask[i] = USED[i] && (word_we || hit);
        assign sw_val[i]  = USED[i] && (hit ? bop_bit : word_in[i]);
    end
endmodule

// File: rtl/flag_hw_update.sv
module flag_hw_update
    import status_flag_pkg::*;
(
    input  stat_word_t       cur,
    input  logic             alu_done,
    input  logic             alu_carry,
    input  logic             alu_ovf,
    input  logic             fp_done,
    input  logic             fp_ovf,
    input  logic             kbit_we,
    input  logic             kbit,
    input  logic             shift_done,
    input  logic             shift_link,
    input  logic             lvl_we,
    input  logic [LVL_W-1:0] lvl,
    output stat_word_t       hw_next
);
    always_comb begin
        hw_next = cur;
        if (alu_done) begin
            hw_next.c = alu_carry;
            hw_next.q = alu_ovf;
            hw_next.o = cur.o | alu_ovf;
        end
        if (fp_done && fp_ovf) begin
            hw_next.z = 1'b1;
        end
        if (kbit_we) begin
            hw_next.k = kbit;
        end
        if (shift_done) begin
            hw_next.m = shift_link;
        end
        if (lvl_we) begin
            hw_next.level = lvl;
        end
    end
endmodule

// File: rtl/status_flag_reg.sv
module status_flag_reg
    import status_flag_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mclr_i,
    input  logic              alu_done_i,
    input  logic              alu_carry_i,
    input  logic              alu_ovf_i,
    input  logic              fp_done_i,
    input  logic              fp_ovf_i,
    input  logic              kbit_we_i,
    input  logic              kbit_i,
    input  logic              shift_done_i,
    input  logic              shift_link_i,
    input  logic              lvl_we_i,
    input  logic [LVL_W-1:0]  lvl_i,
    input  logic              word_we_i,
    input  logic [STAT_W-1:0] word_i,
    input  logic              bop_en_i,
    input  logic [SEL_W-1:0]  bop_sel_i,
    input  logic [1:0]        bop_op_i,
    input  logic              bop_val_i,
    output logic [STAT_W-1:0] word_o
);
    stat_word_t        state_q;
    stat_word_t        state_d;
    stat_word_t        hw_next;
    logic [STAT_W-1:0] sw_mask;
    logic [STAT_W-1:0] sw_val;

    flag_hw_update u_hw (
        .cur        (state_q),
        .alu_done   (alu_done_i),
        .alu_carry  (alu_carry_i),
        .alu_ovf    (alu_ovf_i),
        .fp_done    (fp_done_i),
        .fp_ovf     (fp_ovf_i),
        .kbit_we    (kbit_we_i),
        .kbit       (kbit_i),
        .shift_done (shift_done_i),
        .shift_link (shift_link_i),
        .lvl_we     (lvl_we_i),
        .lvl        (lvl_i),
        .hw_next    (hw_next)
    );

    flag_sw_decode #(
        .W    (STAT_W),
        .SW   (SEL_W),
        .USED (USED_MASK)
    ) u_sw (
        .word_we (word_we_i),
        .word_in (word_i),
        .bop_en  (bop_en_i),
        .bop_sel (bop_sel_i),
        .bop_op  (bop_op_i),
        .bop_val (bop_val_i),
        .sw_mask (sw_mask),
        .sw_val  (sw_val)
    );

    // Software-written bits override hardware results; clear overrides all.
    always_comb begin
        logic [STAT_W-1:0] merged;
        merged  = (STAT_W'(hw_next) & ~sw_mask) | (sw_val & sw_mask);
        state_d = stat_word_t'(merged & USED_MASK);
        if (mclr_i) begin
            state_d = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign word_o = STAT_W'(state_q);
endmodule

// File: rtl/status_flag_chk.sv
module status_flag_chk
    import status_flag_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              mclr_i,
    input logic              alu_done_i,
    input logic              alu_ovf_i,
    input logic              fp_done_i,
    input logic              kbit_we_i,
    input logic              shift_done_i,
    input logic              lvl_we_i,
    input logic              word_we_i,
    input logic [STAT_W-1:0] word_i,
    input logic              bop_en_i,
    input logic [SEL_W-1:0]  bop_sel_i,
    input logic [1:0]        bop_op_i,
    input logic [STAT_W-1:0] word_o
);
    logic bop_live;
    logic hit_z, hit_q, hit_o;
    logic quiet;
    assign bop_live = bop_en_i && (bop_op_i != 2'd3);
    assign hit_z = bop_live && (bop_sel_i == SEL_W'(POS_Z));
    assign hit_q = bop_live && (bop_sel_i == SEL_W'(POS_Q));
    assign hit_o = bop_live && (bop_sel_i == SEL_W'(POS_O));
    assign quiet = !mclr_i && !alu_done_i && !fp_done_i && !kbit_we_i &&
                   !shift_done_i && !lvl_we_i && !word_we_i && !bop_live;

    a_r2_unused_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (word_o & ~USED_MASK) == '0);

    a_r10_mclr_clears: assert property (@(posedge clk) disable iff (!rst_n)
        mclr_i |=> word_o == '0);

    a_r3_q_follows: assert property (@(posedge clk) disable iff (!rst_n)
        (alu_done_i && !mclr_i && !word_we_i && !hit_q)
        |=> word_o[POS_Q] == $past(alu_ovf_i));

    a_r4_o_sets: assert property (@(posedge clk) disable iff (!rst_n)
        (alu_done_i && alu_ovf_i && !mclr_i && !word_we_i && !hit_o)
        |=> word_o[POS_O]);

    a_r4_o_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (word_o[POS_O] && !mclr_i && !word_we_i && !hit_o) |=> word_o[POS_O]);

    a_r5_z_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (word_o[POS_Z] && !mclr_i && !word_we_i && !hit_z) |=> word_o[POS_Z]);

    a_r7_word_load: assert property (@(posedge clk) disable iff (!rst_n)
        (word_we_i && !bop_en_i && !mclr_i)
        |=> word_o == ($past(word_i) & USED_MASK));

    a_r11_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
        quiet |=> $stable(word_o));
endmodule

bind status_flag_reg status_flag_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .mclr_i       (mclr_i),
    .alu_done_i   (alu_done_i),
    .alu_ovf_i    (alu_ovf_i),
    .fp_done_i    (fp_done_i),
    .kbit_we_i    (kbit_we_i),
    .shift_done_i (shift_done_i),
    .lvl_we_i     (lvl_we_i),
    .word_we_i    (word_we_i),
    .word_i       (word_i),
    .bop_en_i     (bop_en_i),
    .bop_sel_i    (bop_sel_i),
    .bop_op_i     (bop_op_i),
    .word_o       (word_o)
);

// File: tb/status_flag_reg_tb_top.sv
`timescale 1ns/1ps
module status_flag_reg_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        mclr_i = 0, alu_done_i = 0, alu_carry_i = 0, alu_ovf_i = 0;
    logic        fp_done_i = 0, fp_ovf_i = 0, kbit_we_i = 0, kbit_i = 0;
    logic        shift_done_i = 0, shift_link_i = 0, lvl_we_i = 0;
    logic [3:0]  lvl_i = '0;
    logic        word_we_i = 0;
    logic [15:0] word_i = '0;
    logic        bop_en_i = 0;
    logic [3:0]  bop_sel_i = '0;
    logic [1:0]  bop_op_i = '0;
    logic        bop_val_i = 0;
    logic [15:0] word_o;

    localparam logic [15:0] USED = 16'h6FFC;

    int          n_checks = 0;
    int          n_errors = 0;
    bit          run_done = 0;
    logic [15:0] model = '0;
    logic [15:0] exp_q[$];
    string       tag_q[$];

    always #10 clk = ~clk;

    status_flag_reg dut_i (
        .clk(clk), .rst_n(rst_n), .mclr_i(mclr_i),
        .alu_done_i(alu_done_i), .alu_carry_i(alu_carry_i), .alu_ovf_i(alu_ovf_i),
        .fp_done_i(fp_done_i), .fp_ovf_i(fp_ovf_i),
        .kbit_we_i(kbit_we_i), .kbit_i(kbit_i),
        .shift_done_i(shift_done_i), .shift_link_i(shift_link_i),
        .lvl_we_i(lvl_we_i), .lvl_i(lvl_i),
        .word_we_i(word_we_i), .word_i(word_i),
        .bop_en_i(bop_en_i), .bop_sel_i(bop_sel_i), .bop_op_i(bop_op_i),
        .bop_val_i(bop_val_i), .word_o(word_o)
    );

    task automatic check(input logic [15:0] act, input logic [15:0] exp, input string tag);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic idle_inputs();
        mclr_i = 0; alu_done_i = 0; alu_carry_i = 0; alu_ovf_i = 0;
        fp_done_i = 0; fp_ovf_i = 0; kbit_we_i = 0; kbit_i = 0;
        shift_done_i = 0; shift_link_i = 0; lvl_we_i = 0; lvl_i = '0;
        word_we_i = 0; word_i = '0; bop_en_i = 0; bop_sel_i = '0;
        bop_op_i = '0; bop_val_i = 0;
    endtask

    // Expected next word from the requirements.
    function automatic logic [15:0] next_word(input logic [15:0] cur);
        logic [15:0] n;
        n = cur;
        if (alu_done_i) begin
            n[6] = alu_carry_i;
            n[4] = alu_ovf_i;
            if (alu_ovf_i) n[5] = 1'b1;
        end
        if (fp_done_i && fp_ovf_i) n[3] = 1'b1;
        if (kbit_we_i) n[2] = kbit_i;
        if (shift_done_i) n[7] = shift_link_i;
        if (lvl_we_i) n[11:8] = lvl_i;
        if (word_we_i) n = (n & ~USED) | (word_i & USED);
        if (bop_en_i && bop_op_i != 2'd3 && USED[bop_sel_i])
            n[bop_sel_i] = (bop_op_i == 2'd1) || (bop_op_i == 2'd2 && bop_val_i);
        n = n & USED;
        if (mclr_i) n = '0;
        return n;
    endfunction

    // Driver: apply current inputs for one edge and queue the expected word.
    task automatic step(input string tag);
        logic [15:0] e;
        e = next_word(model);
        @(posedge clk);
        #1;
        model = e;
        exp_q.push_back(e);
        tag_q.push_back(tag);
        @(negedge clk);
        idle_inputs();
    endtask

    // Monitor: compare queued expectations one edge after they were driven.
    always @(negedge clk) begin
        if (exp_q.size() > 0) begin
            check(word_o, exp_q.pop_front(), tag_q.pop_front());
        end
    end

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    endtask

    initial begin
        repeat (5000) @(posedge clk);
        if (!run_done) begin
            n_checks++;
            n_errors++;
            $display("FAIL watchdog: actual=hung expected=done");
            finish_run();
        end
    end

    initial begin
        idle_inputs();
        repeat (3) @(negedge clk);
        check(word_o, 16'h0000, "R10 reset state");
        rst_n = 1'b1;
        @(negedge clk);
        step("R11 idle after reset");

        word_we_i = 1; word_i = 16'hFFFF;         step("R2 R7 full word write");
        mclr_i = 1; alu_done_i = 1; alu_ovf_i = 1; word_we_i = 1; word_i = 16'h1234;
        step("R10 master clear priority");
        kbit_we_i = 1; kbit_i = 1;                step("R1 accumulator at bit 2");
        check(word_o, 16'h0004, "R1 direct layout K");
        alu_done_i = 1; alu_carry_i = 1; alu_ovf_i = 1; step("R3 R4 carry and overflow");
        alu_done_i = 1;                           step("R3 R4 no overflow keeps static");
        step("R11 idle hold");
        fp_done_i = 1; fp_ovf_i = 1;              step("R5 floating overflow sets");
        fp_done_i = 1;                            step("R5 floating no overflow holds");
        shift_done_i = 1; shift_link_i = 1; lvl_we_i = 1; lvl_i = 4'hA;
        step("R6 link and level");
        kbit_we_i = 1; kbit_i = 0;                step("R6 accumulator cleared");
        bop_en_i = 1; bop_sel_i = 4'd5; bop_op_i = 2'd0; step("R8 clear static overflow");
        bop_en_i = 1; bop_sel_i = 4'd13; bop_op_i = 2'd1; step("R8 set paging");
        bop_en_i = 1; bop_sel_i = 4'd14; bop_op_i = 2'd2; bop_val_i = 1; step("R8 load reject");
        bop_en_i = 1; bop_sel_i = 4'd6; bop_op_i = 2'd3; step("R8 no-op action");
        bop_en_i = 1; bop_sel_i = 4'd0; bop_op_i = 2'd1; step("R2 bit op on bit 0");
        bop_en_i = 1; bop_sel_i = 4'd15; bop_op_i = 2'd2; bop_val_i = 1; step("R2 bit op on bit 15");
        bop_en_i = 1; bop_sel_i = 4'd12; bop_op_i = 2'd1; step("R2 bit op on bit 12");
        alu_done_i = 1; alu_ovf_i = 1; bop_en_i = 1; bop_sel_i = 4'd5; bop_op_i = 2'd0;
        step("R9 bit clear beats overflow");
        alu_done_i = 1; alu_carry_i = 1; word_we_i = 1; word_i = 16'h0000;
        step("R9 word write beats carry");
        fp_done_i = 1; fp_ovf_i = 1; step("R5 set again");
        fp_done_i = 1; fp_ovf_i = 1; bop_en_i = 1; bop_sel_i = 4'd3; bop_op_i = 2'd0;
        step("R9 bit clear beats floating overflow");
        word_we_i = 1; word_i = 16'hFFFF; bop_en_i = 1; bop_sel_i = 4'd6; bop_op_i = 2'd0;
        step("R9 bit op beats word write");
        lvl_we_i = 1; lvl_i = 4'h3; word_we_i = 1; word_i = 16'h0500;
        step("R9 word write beats level strobe");
        begin
            logic [15:0] pat;
            pat = 16'hACE1;
            for (int i = 0; i < 8; i++) begin
                pat = {pat[14:0], pat[15] ^ pat[13] ^ pat[12] ^ pat[10]};
                word_we_i = 1; word_i = pat;
                step("R7 word write pattern");
            end
        end
        mclr_i = 1; step("R10 master clear");
        step("R11 idle after clear");
        run_done = 1;
        @(negedge clk);
        finish_run();
    end
endmodule